// File: doc/BRIEF.md
# DMA Descriptor Ring Engine

This block serves one descriptor ring of a host DMA controller. Software sets the ring's base address, its size in entries and a four-bit control field, then moves a producer index forward through an index register. Whenever the ring is enabled and the consumer index differs from the producer index, the engine reads the 16-byte descriptor at the consumer slot as four 32-bit words over a simple request/acknowledge memory port. It then holds the descriptor in a fixed-latency transfer stage that stands in for payload movement, and rewrites the descriptor's third word with completion status when the descriptor asks for it. A one-cycle event goes to the interrupt block when the descriptor asks for one.

The same engine handles transmit and receive rings, selected by an input. A transmit descriptor gets only its done flag set. A receive descriptor is rewritten in its posted form. In that form the length comes from the transfer stub, clipped to the ring's buffer size. The end and start codes also come from the stub, and the CRC-error and overrun flags are filled in. A sticky watermark bit records that the consumer index has reached a programmed slot.

Top module: `dma_ring_engine`

## Requirements
- R1: With the ring enabled (cfg_ctrl bit 3) and not empty, the engine reads the four words of slot C at byte addresses base+16*C, +4, +8 and +12, in that order. Each request is held with a stable address and direction until mem_ack.
- R2: No memory request is issued while the consumer index equals the producer index, or while cfg_ctrl bit 3 is clear.
- R3: idx_value reads {producer, consumer} with the consumer in bits 15:0. An index write loads the producer from bits 31:16. It loads the consumer from bits 15:0 only while the ring is disabled, and a consumer value written while enabled is ignored.
- R4: After each completed descriptor the consumer index advances by one, and it wraps to 0 after index cfg_size[15:0]-1.
- R5: xfer_busy is high for exactly XFER_LAT cycles per descriptor, with no memory request during that time. The stub inputs are sampled in its last cycle, and xfer_e2e mirrors cfg_ctrl bit 0 while busy.
- R6: Status is written back only when bit 22 of descriptor word 2 (flags bit 6) is set. It is one write of word 2 at base+16*C+8. For a transmit ring the written word equals the fetched word with bit 21 (done) set.
- R7: For a receive ring the written word 2 is built as follows. Bits 11:0 hold the stub length clipped to cfg_size[31:16]. Bits 15:12 hold the stub end code and bits 19:16 the stub start code. Bit 20 holds the CRC error, reported only when cfg_ctrl bit 2 (raw) is clear. Bit 21 is 1. Bit 22 holds the overrun: the stub overrun, or a length over the buffer size. Bits 31:23 are kept from the fetched word.
- R8: evt pulses for exactly one cycle per completed descriptor whose word 2 bit 23 (interrupt enable) is set, and stays low for other descriptors.
- R9: wm_status is set when the consumer index advances onto cfg_wmark and stays set until wm_clr; a set in the same cycle wins over a clear.
- R10: mem_nosnoop equals cfg_ctrl bit 1 on every memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 64 | Ring base byte address |
| cfg_size | input | 32 | Ring entries in 15:0, receive buffer size in 31:16 |
| cfg_ctrl | input | 4 | bit 3 enable, bit 2 raw mode, bit 1 no-snoop, bit 0 end-to-end flow control |
| ring_is_rx | input | 1 | 1 selects the receive descriptor format |
| cfg_wmark | input | 16 | Watermark slot index |
| idx_wr | input | 1 | Index register write strobe |
| idx_wdata | input | 32 | Index write data {producer, consumer} |
| idx_value | output | 32 | Index register {producer, consumer} |
| wm_clr | input | 1 | Clears the watermark status |
| wm_status | output | 1 | Sticky watermark status |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_nosnoop | output | 1 | No-snoop attribute of the request |
| mem_addr | output | 64 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the held request |
| xfer_busy | output | 1 | Transfer stub stage active |
| xfer_buf_addr | output | 64 | Buffer address from the descriptor |
| xfer_ptime | output | 32 | Payload time word from the descriptor |
| xfer_e2e | output | 1 | Flow-control attribute of the transfer |
| stub_len | input | 12 | Received byte count from the stub |
| stub_eof | input | 4 | End-of-frame code from the stub |
| stub_sof | input | 4 | Start-of-frame code from the stub |
| stub_crc_err | input | 1 | CRC error from the stub |
| stub_overrun | input | 1 | Overrun from the stub |
| evt | output | 1 | Completion event pulse |

## Verification
The hardest case to reach is a consumer-index write arriving while the ring is enabled. That write has to be discarded, and the check needs a producer move in the same write so that the engine's later progress shows what happened. The bench does this mid-run on a transmit ring and then follows the consumer through a wrap at a ring size of four, landing on the watermark slot. Receive posting is driven with a length above the buffer size and a CRC error in raw mode. The bench reads back the rewritten descriptor words, which shows the clipping, the forced overrun and the CRC bit suppressed in raw mode.

// File: rtl/dma_ring_pkg.sv
// Shared types and descriptor field positions for the descriptor ring engine.
// Assumes little-endian packing of descriptor word 2: {offset, flags, len/eof}.
package dma_ring_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_XFER  = 3'd2,
        S_WBACK = 3'd3,
        S_DONE  = 3'd4
    } seq_state_t;

    localparam int W2_IE_BIT   = 23;
    localparam int W2_RS_BIT   = 22;
    localparam int W2_OVR_BIT  = 22;
    localparam int W2_DONE_BIT = 21;
    localparam int W2_CRC_BIT  = 20;
    localparam int LEN_W       = 12;
    localparam int CODE_W      = 4;
endpackage

// File: rtl/ring_index_regs.sv
// Producer/consumer index pair and watermark flag of one ring.
// Assumes advance is a single-cycle strobe issued once per completed descriptor.
module ring_index_regs #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [2*IDX_W-1:0] idx_wdata,
    input  logic             ring_valid,
    input  logic             advance,
    input  logic [IDX_W-1:0] ring_size,
    input  logic [IDX_W-1:0] wmark,
    input  logic             wm_clr,
    output logic [IDX_W-1:0] prod,
    output logic [IDX_W-1:0] cons,
    output logic             empty,
    output logic             wm_status
);
    logic [IDX_W-1:0] cons_nxt;

    // next consumer slot with wrap at the last entry
    always_comb cons_nxt = (cons == ring_size - IDX_W'(1)) ? '0 : cons + IDX_W'(1);

    // ring is empty when both indices meet
    always_comb empty = (cons == prod);

    // index updates: engine advance, then software load while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
            cons <= '0;
        end else begin
            if (advance)
                cons <= cons_nxt;
            if (idx_wr) begin
                prod <= idx_wdata[2*IDX_W-1:IDX_W];
                if (!ring_valid)
                    cons <= idx_wdata[IDX_W-1:0];
            end
        end
    end

    // sticky watermark flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            wm_status <= 1'b0;
        else if (advance && (cons_nxt == wmark))
            wm_status <= 1'b1;
        else if (wm_clr)
            wm_status <= 1'b0;
    end
endmodule

// File: rtl/desc_post.sv
// Builds the completion value of descriptor word 2 from the fetched word
// and the transfer stub results. Purely combinational.
module desc_post
    import dma_ring_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic              is_rx,
    input  logic              raw_mode,
    input  logic [IDX_W-1:0]  buf_size,
    input  logic [31:0]       req_word,
    input  logic [LEN_W-1:0]  stub_len,
    input  logic [CODE_W-1:0] stub_eof,
    input  logic [CODE_W-1:0] stub_sof,
    input  logic              stub_crc_err,
    input  logic              stub_overrun,
    output logic [31:0]       post_word
);
    logic             too_long;
    logic [LEN_W-1:0] clip_len;

    // length clipping against the receive buffer size
    always_comb begin
        too_long = 32'(stub_len) > 32'(buf_size);
        clip_len = too_long ? buf_size[LEN_W-1:0] : stub_len;
    end

    // format selection: transmit sets done, receive posts full status
    always_comb begin
        if (is_rx) begin
            post_word = {req_word[31:W2_IE_BIT],
                         stub_overrun | too_long,
                         1'b1,
                         stub_crc_err & ~raw_mode,
                         stub_sof, stub_eof, clip_len};
        end else begin
            post_word = req_word;
            post_word[W2_DONE_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/ring_sequencer.sv
// Walks one descriptor at a time: fetch four words, hold for the transfer
// stub latency, optionally write back word 2, then advance the consumer.
// Assumes the memory port holds no more than one outstanding request.
module ring_sequencer
    import dma_ring_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int IDX_W    = 16,
    parameter int XFER_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_valid,
    input  logic              empty,
    input  logic [IDX_W-1:0]  cons,
    input  logic [ADDR_W-1:0] base,
    input  logic [31:0]       post_word,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [63:0]       buf_addr,
    output logic [31:0]       desc_w2,
    output logic [31:0]       ptime,
    output logic              busy,
    output logic              advance,
    output logic              evt,
    output logic              idle
);
    localparam int TMR_W = $clog2(XFER_LAT + 1);

    seq_state_t        state;
    logic [1:0]        wcnt;
    logic [TMR_W-1:0]  tmr;
    logic [31:0]       wb_word;
    logic [ADDR_W-1:0] slot_addr;

    // byte address of the current slot and of the word in flight
    always_comb begin
        slot_addr = base + (ADDR_W'(cons) << 4);
        mem_addr  = slot_addr + ((state == S_WBACK) ? ADDR_W'(8) : ADDR_W'({wcnt, 2'b00}));
    end

    // port strobes decoded from the state register
    always_comb begin
        mem_req   = (state == S_FETCH) || (state == S_WBACK);
        mem_we    = (state == S_WBACK);
        mem_wdata = wb_word;
        busy      = (state == S_XFER);
        advance   = (state == S_DONE);
        evt       = (state == S_DONE) && desc_w2[W2_IE_BIT];
        idle      = (state == S_IDLE);
    end

    // descriptor walk state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            wcnt     <= '0;
            tmr      <= '0;
            wb_word  <= '0;
            buf_addr <= '0;
            desc_w2  <= '0;
            ptime    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (ring_valid && !empty) begin
                        state <= S_FETCH;
                        wcnt  <= '0;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        case (wcnt)
                            2'd0:    buf_addr[31:0]  <= mem_rdata;
                            2'd1:    buf_addr[63:32] <= mem_rdata;
                            2'd2:    desc_w2         <= mem_rdata;
                            default: ptime           <= mem_rdata;
                        endcase
                        wcnt <= wcnt + 2'd1;
                        if (wcnt == 2'd3) begin
                            state <= S_XFER;
                            tmr   <= TMR_W'(XFER_LAT - 1);
                        end
                    end
                end
                S_XFER: begin
                    if (tmr == '0) begin
                        wb_word <= post_word;
                        state   <= desc_w2[W2_RS_BIT] ? S_WBACK : S_DONE;
                    end else begin
                        tmr <= tmr - TMR_W'(1);
                    end
                end
                S_WBACK: begin
                    if (mem_ack)
                        state <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_ring_engine.sv
// Top of the per-ring descriptor engine: index registers, sequencer and
// completion formatter. Assumes configuration is changed only while idle
// or disabled, apart from the enable bit and index writes.
module dma_ring_engine
    import dma_ring_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int IDX_W    = 16,
    parameter int XFER_LAT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [2*IDX_W-1:0]   cfg_size,
    input  logic [3:0]           cfg_ctrl,
    input  logic                 ring_is_rx,
    input  logic [IDX_W-1:0]     cfg_wmark,
    input  logic                 idx_wr,
    input  logic [2*IDX_W-1:0]   idx_wdata,
    output logic [2*IDX_W-1:0]   idx_value,
    input  logic                 wm_clr,
    output logic                 wm_status,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_nosnoop,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    input  logic                 mem_ack,
    output logic                 xfer_busy,
    output logic [63:0]          xfer_buf_addr,
    output logic [31:0]          xfer_ptime,
    output logic                 xfer_e2e,
    input  logic [LEN_W-1:0]     stub_len,
    input  logic [CODE_W-1:0]    stub_eof,
    input  logic [CODE_W-1:0]    stub_sof,
    input  logic                 stub_crc_err,
    input  logic                 stub_overrun,
    output logic                 evt
);
    logic             ring_valid;
    logic [IDX_W-1:0] prod;
    logic [IDX_W-1:0] cons;
    logic             empty;
    logic             advance;
    logic             seq_idle;
    logic [31:0]      desc_w2;
    logic [31:0]      post_word;

    // control field decode and attribute outputs
    always_comb begin
        ring_valid  = cfg_ctrl[3];
        mem_nosnoop = cfg_ctrl[1];
        xfer_e2e    = xfer_busy & cfg_ctrl[0];
        idx_value   = {prod, cons};
    end

    ring_index_regs #(.IDX_W(IDX_W)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .idx_wdata (idx_wdata),
        .ring_valid(ring_valid),
        .advance   (advance),
        .ring_size (cfg_size[IDX_W-1:0]),
        .wmark     (cfg_wmark),
        .wm_clr    (wm_clr),
        .prod      (prod),
        .cons      (cons),
        .empty     (empty),
        .wm_status (wm_status)
    );

    desc_post #(.IDX_W(IDX_W)) u_post (
        .is_rx       (ring_is_rx),
        .raw_mode    (cfg_ctrl[2]),
        .buf_size    (cfg_size[2*IDX_W-1:IDX_W]),
        .req_word    (desc_w2),
        .stub_len    (stub_len),
        .stub_eof    (stub_eof),
        .stub_sof    (stub_sof),
        .stub_crc_err(stub_crc_err),
        .stub_overrun(stub_overrun),
        .post_word   (post_word)
    );

    ring_sequencer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .XFER_LAT(XFER_LAT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_valid(ring_valid),
        .empty     (empty),
        .cons      (cons),
        .base      (cfg_base),
        .post_word (post_word),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .buf_addr  (xfer_buf_addr),
        .desc_w2   (desc_w2),
        .ptime     (xfer_ptime),
        .busy      (xfer_busy),
        .advance   (advance),
        .evt       (evt),
        .idle      (seq_idle)
    );
endmodule

// File: rtl/dma_ring_engine_chk.sv
// Protocol and status checks for dma_ring_engine, attached by bind.
module dma_ring_engine_chk #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              evt,
    input logic              ring_valid,
    input logic              in_idle,
    input logic              rs_flag,
    input logic              wm_status,
    input logic [IDX_W-1:0]  cons,
    input logic [IDX_W-1:0]  wmark,
    input logic              xfer_busy
);
    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2
    no_fetch_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && !ring_valid) |=> !mem_req);

    // R5
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |-> !mem_req);

    // R6
    wb_needs_rs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> rs_flag);

    // R8
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    // R9
    wm_at_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wm_status) |-> (cons == wmark));
endmodule

bind dma_ring_engine dma_ring_engine_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .evt       (evt),
    .ring_valid(ring_valid),
    .in_idle   (seq_idle),
    .rs_flag   (desc_w2[22]),
    .wm_status (wm_status),
    .cons      (cons),
    .wmark     (cfg_wmark),
    .xfer_busy (xfer_busy)
);

// File: tb/dma_ring_engine_test.sv
module dma_ring_engine_test;
    localparam logic [63:0] BASE = 64'h0000_0001_0000_0400;
    localparam logic [3:0] EN = 4'b1000, RAW = 4'b0100, NS = 4'b0010, E2E = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_size = 32'h0064_0004;
    logic [3:0]  cfg_ctrl = 4'b0000;
    logic        ring_is_rx = 1'b0;
    logic [15:0] cfg_wmark = 16'd0;
    logic        idx_wr = 1'b0;
    logic [31:0] idx_wdata = '0;
    logic [31:0] idx_value;
    logic        wm_clr = 1'b0;
    logic        wm_status;
    logic        mem_req, mem_we, mem_nosnoop;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        xfer_busy, xfer_e2e;
    logic [63:0] xfer_buf_addr;
    logic [31:0] xfer_ptime;
    logic [11:0] stub_len = '0;
    logic [3:0]  stub_eof = '0, stub_sof = '0;
    logic        stub_crc_err = 1'b0, stub_overrun = 1'b0;
    logic        evt;

    logic [31:0] mem [64];
    logic [63:0] rd_log [64];
    int rd_cnt = 0, wr_cnt = 0, evt_cnt = 0, busy_cnt = 0, ns_err = 0, e2e_hi = 0;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    dma_ring_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_size(cfg_size),
        .cfg_ctrl(cfg_ctrl), .ring_is_rx(ring_is_rx), .cfg_wmark(cfg_wmark),
        .idx_wr(idx_wr), .idx_wdata(idx_wdata), .idx_value(idx_value),
        .wm_clr(wm_clr), .wm_status(wm_status), .mem_req(mem_req), .mem_we(mem_we),
        .mem_nosnoop(mem_nosnoop), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .xfer_busy(xfer_busy),
        .xfer_buf_addr(xfer_buf_addr), .xfer_ptime(xfer_ptime), .xfer_e2e(xfer_e2e),
        .stub_len(stub_len), .stub_eof(stub_eof), .stub_sof(stub_sof),
        .stub_crc_err(stub_crc_err), .stub_overrun(stub_overrun), .evt(evt)
    );

    // memory model: acknowledges one cycle after each request
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (evt) evt_cnt <= evt_cnt + 1;
        if (xfer_busy) busy_cnt <= busy_cnt + 1;
        if (xfer_e2e) e2e_hi <= e2e_hi + 1;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_nosnoop !== cfg_ctrl[1]) ns_err <= ns_err + 1;
            if (mem_we) begin
                mem[6'((mem_addr - BASE) >> 2)] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[6'((mem_addr - BASE) >> 2)];
                rd_log[rd_cnt[5:0]] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_idx(input logic [31:0] v);
        @(negedge clk); idx_wdata = v; idx_wr = 1'b1;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic wait_cons(input logic [15:0] c);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (idx_value[15:0] == c && !mem_req && !xfer_busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic put_desc(input int slot, input logic [31:0] w2);
        mem[slot*4]   = 32'hB000_0000 + 32'(slot);
        mem[slot*4+1] = 32'h0000_00AB;
        mem[slot*4+2] = w2;
        mem[slot*4+3] = 32'h7000_0000 + 32'(slot);
    endtask

    task automatic t_reset;
        chk("R3 reset index", 64'(idx_value), 64'h0);
        chk("R9 reset watermark", 64'(wm_status), 64'h0);
        chk("R2 reset no request", 64'(mem_req), 64'h0);
    endtask

    task automatic t_disabled;
        write_idx(32'h0002_0000);
        repeat (20) @(negedge clk);
        chk("R2 disabled ring makes no reads", 64'(rd_cnt), 64'd0);
        chk("R3 index after disabled write", 64'(idx_value), 64'h0002_0000);
    endtask

    task automatic t_tx;
        int r0;
        r0 = rd_cnt;
        cfg_ctrl = EN | E2E;
        wait_cons(16'd2);
        chk("R1 eight words read", 64'(rd_cnt - r0), 64'd8);
        for (int i = 0; i < 8; i++)
            chk("R1 read address order", rd_log[6'(r0 + i)], BASE + 64'(i * 4));
        chk("R6 tx done written", 64'(mem[2]), 64'h11E1_2040);
        chk("R6 no write without request", 64'(mem[6]), 64'h2280_0010);
        chk("R6 single write", 64'(wr_cnt), 64'd1);
        chk("R8 two events", 64'(evt_cnt), 64'd2);
        chk("R5 e2e mirrored while busy", 64'(e2e_hi), 64'd8);
        chk("R4 buffer address", xfer_buf_addr, 64'h0000_00AB_B000_0001);
        write_idx(32'h0003_0001);
        chk("R3 consumer write ignored when enabled", 64'(idx_value[31:16]), 64'h3);
        wait_cons(16'd3);
        chk("R3 consumer continued from 2", 64'(idx_value), 64'h0003_0003);
        chk("R8 no event without enable", 64'(evt_cnt), 64'd2);
        chk("R6 tx word 2 slot 2", 64'(mem[10]), 64'h3360_0008);
        chk("R9 not yet set", 64'(wm_status), 64'h0);
    endtask

    task automatic t_wrap;
        write_idx(32'h0000_0003);
        wait_cons(16'd0);
        chk("R4 wrap to zero", 64'(idx_value), 64'h0);
        chk("R6 slot 3 written", 64'(mem[14]), 64'h44E0_0004);
        chk("R8 event count after wrap", 64'(evt_cnt), 64'd3);
        chk("R9 watermark set on slot 0", 64'(wm_status), 64'h1);
        @(negedge clk); wm_clr = 1'b1;
        @(negedge clk); wm_clr = 1'b0;
        chk("R9 watermark cleared", 64'(wm_status), 64'h0);
    endtask

    task automatic t_rx;
        int b0;
        cfg_ctrl = 4'b0000;
        ring_is_rx = 1'b1;
        cfg_wmark = 16'd9;
        put_desc(0, 32'h5AC0_0000);
        put_desc(1, 32'h00C0_0000);
        stub_len = 12'd64; stub_eof = 4'd3; stub_sof = 4'd2;
        stub_crc_err = 1'b1; stub_overrun = 1'b0;
        cfg_ctrl = EN | NS;
        b0 = busy_cnt;
        write_idx(32'h0001_0000);
        wait_cons(16'd1);
        chk("R7 rx posted frame mode", 64'(mem[2]), 64'h5AB2_3040);
        chk("R5 busy length", 64'(busy_cnt - b0), 64'd4);
        cfg_ctrl = EN | NS | RAW;
        stub_len = 12'd200; stub_eof = 4'd1; stub_sof = 4'hF;
        write_idx(32'h0002_0000);
        wait_cons(16'd2);
        chk("R7 rx clipped, overrun, raw crc hidden", 64'(mem[6]), 64'h00EF_1064);
        chk("R8 rx events", 64'(evt_cnt), 64'd5);
        chk("R10 no-snoop on every request", 64'(ns_err), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        put_desc(0, 32'h11C1_2040);
        put_desc(1, 32'h2280_0010);
        put_desc(2, 32'h3340_0008);
        put_desc(3, 32'h44C0_0004);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_tx;
        t_wrap;
        t_rx;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule